// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block controls the power state of an asynchronous single-transistor-cell pseudo-SRAM for a host memory controller. It drives the active-high power-keep line of the memory. Driving that line low puts the memory into deep power down, and the memory stays there for as long as the line is low. The block also tells the access engine, through a ready flag, when cycles may be issued. Ordinary standby, with chip select or both byte enables inactive, is left to the access engine. Standby keeps the stored data and needs no wake time, so this block takes no part in it.

Deep power down costs more. Leaving it destroys the cell contents and needs a settling period strictly longer than 200 µs before the first access. The same wait applies after the supply first becomes stable, which the reset input represents. The block counts that wait in clock cycles, using the clock frequency as a parameter.

Each exit from deep power down raises a sticky data-lost flag. The host clears it with an acknowledge once it has reinitialised the memory. A sleep request is refused while the access engine reports busy. The request is held pending and carried out once the bus is idle.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted and on its release, memPowerOn is 1, ready is 0 and dataLost is 0.
- R2: After reset is released, ready rises exactly WAIT_CYC = CLK_MHZ*WAIT_US+1 rising clock edges later and not before.
- R3: When ready is 1, busy is 0 and sleepReq is 1 at a clock edge, both memPowerOn and ready are 0 after that edge.
- R4: A sleep request seen while ready and busy are both 1 is held pending. memPowerOn and ready stay 1 while busy stays 1. The sleep is taken at the first edge with busy 0, even if sleepReq has returned to 0.
- R5: While in deep power down (memPowerOn 0), memPowerOn stays 0 until a wakeReq is seen, and sleep requests have no effect.
- R6: A wakeReq seen in deep power down sets memPowerOn to 1 and dataLost to 1 after that edge. ready then stays 0 for exactly WAIT_CYC edges after the edge that starts the wait, and rises after that.
- R7: A wakeReq during a settling wait is ignored and does not restart the count.
- R8: A sleepReq during a settling wait is ignored: memPowerOn stays 1 and ready still rises on time.
- R9: dataLost stays 1 until lostAck is seen, and is 0 after the edge that samples lostAck. If a wake and lostAck fall on the same edge, dataLost ends up 1.
- R10: ready is never 1 while memPowerOn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset; its release means the supply is stable |
| sleepReq | input | 1 | Request to enter deep power down |
| wakeReq | input | 1 | Request to leave deep power down |
| busy | input | 1 | Access engine has a cycle in progress |
| lostAck | input | 1 | Host acknowledge that clears dataLost |
| memPowerOn | output | 1 | Power-keep line to the memory; low means deep power down |
| ready | output | 1 | Access engine may start cycles |
| dataLost | output | 1 | Sticky flag: memory contents were lost by a deep power down |

## Verification
Two functions of the block can act on the same clock edge. The wake from deep power down sets the data-lost flag, and the host acknowledge clears it. The bench raises wakeReq and lostAck together in one cycle and expects dataLost to be 1 after that edge. A second case releases busy on the same edge at which a held sleep request becomes effective. The bench expects power-down to follow at exactly that edge, and not one cycle later.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_READY = 2'd1,
    ST_SLEEP = 2'd2
  } pwrState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic setLost;
    logic clrLost;
  } pwrStrobe_t;

endpackage

// File: rtl/psram_pwr_dp.sv
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int WAIT_CYC = 20001,
  parameter int CNT_W    = $clog2(WAIT_CYC + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  pwrStrobe_t strb,
  output logic       cntLast,
  output logic       dataLost
);

  logic [CNT_W-1:0] waitCnt;

  // settle counter, loaded on power-up and on every wake
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= CNT_W'(WAIT_CYC);
    end else if (strb.loadCnt) begin
      waitCnt <= CNT_W'(WAIT_CYC);
    end else if (strb.decCnt) begin
      waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign cntLast = (waitCnt == CNT_W'(1));

  // sticky lost flag; a set wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataLost <= 1'b0;
    end else if (strb.setLost) begin
      dataLost <= 1'b1;
    end else if (strb.clrLost) begin
      dataLost <= 1'b0;
    end
  end

endmodule

// File: rtl/psram_pwr_ctl.sv
module psram_pwr_ctl
  import psram_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       wakeReq,
  input  logic       busy,
  input  logic       lostAck,
  input  logic       cntLast,
  output pwrStrobe_t strb,
  output logic       memPowerOn,
  output logic       ready
);

  pwrState_t state, stateNxt;
  logic      sleepPend;
  logic      sleepTake;

  assign sleepTake = (state == ST_READY) && (sleepReq || sleepPend) && !busy;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    strb.clrLost = lostAck;
    unique case (state)
      ST_WAIT: begin
        strb.decCnt = 1'b1;
        if (cntLast) stateNxt = ST_READY;
      end
      ST_READY: begin
        if (sleepTake) stateNxt = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wakeReq) begin
          stateNxt     = ST_WAIT;
          strb.loadCnt = 1'b1;
          strb.setLost = 1'b1;
        end
      end
      default: stateNxt = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WAIT;
    end else begin
      state <= stateNxt;
    end
  end

  // a sleep request held off by busy is remembered until taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepPend <= 1'b0;
    end else if (state != ST_READY || sleepTake) begin
      sleepPend <= 1'b0;
    end else if (sleepReq && busy) begin
      sleepPend <= 1'b1;
    end
  end

  assign memPowerOn = (state != ST_SLEEP);
  assign ready      = (state == ST_READY);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic busy,
  input  logic lostAck,
  output logic memPowerOn,
  output logic ready,
  output logic dataLost
);

  // strictly longer than the settle time
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US + 1;
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);

  pwrStrobe_t strb;
  logic       cntLast;

  psram_pwr_ctl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .busy      (busy),
    .lostAck   (lostAck),
    .cntLast   (cntLast),
    .strb      (strb),
    .memPowerOn(memPowerOn),
    .ready     (ready)
  );

  psram_pwr_dp #(
    .WAIT_CYC(WAIT_CYC),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cntLast (cntLast),
    .dataLost(dataLost)
  );

endmodule

// File: rtl/psram_pwr_chk.sv
module psram_pwr_chk #(
  parameter int WAIT_CYC = 20001
) (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic wakeReq,
  input logic busy,
  input logic lostAck,
  input logic memPowerOn,
  input logic ready,
  input logic dataLost
);

  // counts edges spent awake and not ready
  logic [31:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt <= '0;
    end else if (!memPowerOn) begin
      upCnt <= '0;
    end else if (!ready) begin
      upCnt <= upCnt + 32'd1;
    end
  end

  a_r2_wait_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (upCnt == 32'(WAIT_CYC)));

  a_r3_sleep_take: assert property (@(posedge clk) disable iff (!rstN)
    (ready && sleepReq && !busy) |=> (!memPowerOn && !ready));

  a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ready && busy) |=> (ready && memPowerOn));

  a_r5_stays_down: assert property (@(posedge clk) disable iff (!rstN)
    (!memPowerOn && !wakeReq) |=> !memPowerOn);

  a_r6_wake_lost: assert property (@(posedge clk) disable iff (!rstN)
    (!memPowerOn && wakeReq) |=> (memPowerOn && dataLost && !ready));

  a_r8_wait_awake: assert property (@(posedge clk) disable iff (!rstN)
    (memPowerOn && !ready) |=> memPowerOn);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (dataLost && !lostAck) |=> dataLost);

  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (lostAck && !(!memPowerOn && wakeReq)) |=> !dataLost);

  a_r10_ready_awake: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> memPowerOn);

endmodule

bind psram_pwr_seq psram_pwr_chk #(.WAIT_CYC(WAIT_CYC)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sleepReq  (sleepReq),
  .wakeReq   (wakeReq),
  .busy      (busy),
  .lostAck   (lostAck),
  .memPowerOn(memPowerOn),
  .ready     (ready),
  .dataLost  (dataLost)
);

// File: tb/psram_pwr_seq_tb_top.sv
module psram_pwr_seq_tb_top;

  localparam int CLK_MHZ = 1;
  localparam int WAIT_US = 20;
  localparam int WC      = CLK_MHZ * WAIT_US + 1;

  typedef struct {
    int    cyc;
    logic  rdy;
    logic  pwr;
    logic  lost;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN, sleepReq, wakeReq, busy, lostAck;
  logic memPowerOn, ready, dataLost;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  psram_pwr_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US)) dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .wakeReq   (wakeReq),
    .busy      (busy),
    .lostAck   (lostAck),
    .memPowerOn(memPowerOn),
    .ready     (ready),
    .dataLost  (dataLost)
  );

  // driver side: sorted insert of expected output at absolute cycle
  task automatic expectAt(input int c, input logic r, input logic p,
                          input logic l, input string tag);
    expItem_t it;
    int idx;
    it.cyc = c; it.rdy = r; it.pwr = p; it.lost = l; it.tag = tag;
    idx = expQ.size();
    for (int i = 0; i < expQ.size(); i++) begin
      if (expQ[i].cyc > c) begin idx = i; break; end
    end
    expQ.insert(idx, it);
  endtask

  task automatic gotoCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor side
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (it.cyc != cyc || ready !== it.rdy || memPowerOn !== it.pwr ||
          dataLost !== it.lost) begin
        fails++;
        $display("FAIL %s cyc %0d: ready/power/lost = %b%b%b expected %b%b%b",
                 it.tag, it.cyc, ready, memPowerOn, dataLost,
                 it.rdy, it.pwr, it.lost);
      end
    end
  end

  initial begin
    int t0, t1, t2, t3, t4, t5;
    rstN = 1'b0; sleepReq = 1'b0; wakeReq = 1'b0; busy = 1'b0; lostAck = 1'b0;
    @(negedge clk);
    expectAt(cyc + 1, 1'b0, 1'b1, 1'b0, "R1 reset");
    repeat (3) @(negedge clk);
    // release: power-up wait (R2), disturbed by R7/R8 stimuli
    rstN = 1'b1;
    t0 = cyc;
    expectAt(t0 + 1, 1'b0, 1'b1, 1'b0, "R1 release");
    expectAt(t0 + WC - 1, 1'b0, 1'b1, 1'b0, "R2 early");
    expectAt(t0 + WC, 1'b1, 1'b1, 1'b0, "R2 rise R7");
    gotoCyc(t0 + 5);
    sleepReq = 1'b1; wakeReq = 1'b1;
    expectAt(t0 + 6, 1'b0, 1'b1, 1'b0, "R8 sleep in wait");
    @(negedge clk);
    sleepReq = 1'b0; wakeReq = 1'b0;
    gotoCyc(t0 + WC + 2);
    // held sleep while busy (R4)
    busy = 1'b1; sleepReq = 1'b1;
    t1 = cyc;
    expectAt(t1 + 1, 1'b1, 1'b1, 1'b0, "R4 held");
    expectAt(t1 + 3, 1'b1, 1'b1, 1'b0, "R4 held");
    @(negedge clk);
    sleepReq = 1'b0;
    gotoCyc(t1 + 3);
    busy = 1'b0;
    expectAt(t1 + 4, 1'b0, 1'b0, 1'b0, "R4 taken");
    gotoCyc(t1 + 7);
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    expectAt(t1 + 14, 1'b0, 1'b0, 1'b0, "R5 stays down");
    gotoCyc(t1 + 15);
    // wake (R6)
    t2 = cyc;
    wakeReq = 1'b1;
    expectAt(t2 + 1, 1'b0, 1'b1, 1'b1, "R6 wake");
    expectAt(t2 + WC, 1'b0, 1'b1, 1'b1, "R6 early");
    expectAt(t2 + WC + 1, 1'b1, 1'b1, 1'b1, "R6 rise R9 sticky");
    @(negedge clk);
    wakeReq = 1'b0;
    gotoCyc(t2 + WC + 3);
    // acknowledge (R9)
    t3 = cyc;
    lostAck = 1'b1;
    expectAt(t3 + 1, 1'b1, 1'b1, 1'b0, "R9 ack");
    @(negedge clk);
    lostAck = 1'b0;
    // direct sleep (R3)
    t4 = cyc;
    sleepReq = 1'b1;
    expectAt(t4 + 1, 1'b0, 1'b0, 1'b0, "R3 sleep");
    @(negedge clk);
    sleepReq = 1'b0;
    gotoCyc(t4 + 4);
    // wake and ack on the same edge (R9 set wins)
    t5 = cyc;
    wakeReq = 1'b1; lostAck = 1'b1;
    expectAt(t5 + 1, 1'b0, 1'b1, 1'b1, "R9 set wins");
    expectAt(t5 + WC + 1, 1'b1, 1'b1, 1'b1, "R10 ready awake");
    @(negedge clk);
    wakeReq = 1'b0; lostAck = 1'b0;
    gotoCyc(t5 + WC + 3);
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule